// File: doc/BRIEF.md
# Register access command channel

This block is the host side of a single-access path to an external power-management device. Software writes one command word that holds a write flag, a halfword address and 16 bits of write data. The channel passes the access to a serial back end as a one-cycle request and reports its progress in one packed status word, which software polls.

A write leaves the channel as soon as the request has been issued, so the channel is free again while the back end is still shifting the write out. A read keeps the channel occupied. When the back end's done pulse arrives, the returned halfword is captured and the channel parks until software acknowledges the data with a valid-clear write. Separate select codes on the software write port carry an enable bit and a sticky init-done flag. Software checks the init-done flag before it issues ordinary accesses.

Top module: `reg_access_chan`

## Requirements
- R1: After reset the status word reads 0x0050_0000. The status layout is: read data in [15:0]; state code in [18:16] (IDLE 0, REQ 2, WAIT_DATA 4, WAIT_CLEAR 6); request-pending in bit 19; sync-idle in bit 20; init-done in bit 21; system-idle in bit 22; all other bits 0. No back-end request is raised during or right after reset.
- R2: A command word, written with select 0, has the write flag in bit 31, the halfword address in [30:16] and the write data in [15:0]. When the request is issued, these fields appear on be_write_o, be_addr_o and be_wdata_o.
- R3: A write command goes from IDLE to REQ. It raises be_req_o for exactly one cycle and returns to IDLE in the next cycle.
- R4: A read command goes from IDLE to REQ, then to WAIT_DATA. On be_done_i it captures be_rdata_i into status [15:0] and enters WAIT_CLEAR.
- R5: In WAIT_CLEAR the state and the read data hold until software writes select 1 with bit 0 set. A select-1 write with bit 0 clear has no effect. After a select-1 write with bit 0 set, the state is IDLE one cycle later.
- R6: A command write that arrives in any state other than IDLE is dropped. It issues no request and does not change the held read data.
- R7: The enable bit (select 3, bit 0) is cleared by reset. While it is 0, command writes are dropped and the state stays IDLE.
- R8: Writing select 2 with bit 0 set makes init-done read 1. Writing it with bit 0 clear never clears the flag. Only reset clears it.
- R9: Sync-idle reads 0 from the cycle after a request until the cycle after the back end's done pulse, and reads 1 otherwise. System-idle reads 1 only when the state is IDLE and sync-idle is 1.
- R10: A command accepted while an earlier write is still outstanding waits in REQ with request-pending set. Its request is raised only once the back end has answered the earlier transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_we_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Software write target: 0 command, 1 valid-clear, 2 init-done, 3 enable |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Packed status word |
| be_req_o | output | 1 | One-cycle request to the back end |
| be_write_o | output | 1 | Request is a write |
| be_addr_o | output | 15 | Halfword address |
| be_wdata_o | output | 16 | Write data |
| be_done_i | input | 1 | Back end finished the outstanding transfer |
| be_rdata_i | input | 16 | Read data, valid with be_done_i |

## Verification
The assertions check the following on every cycle:
- each request lasts a single cycle and is never raised while a transfer is outstanding;
- a write goes back to IDLE and a read enters WAIT_DATA;
- the captured data and the WAIT_CLEAR state hold until an acknowledge;
- commands outside IDLE leave the latched command alone;
- init-done never falls.

Only the bench scenarios can show:
- that the right data reaches the status word for a given address history;
- that the status bit positions and the reset value are correct;
- that a disabled channel drops commands without ever raising a request;
- that a queued command waits for the earlier write's done pulse, across randomly chosen back-end latencies.

// File: rtl/reg_chan_pkg.sv
package reg_chan_pkg;

  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd2,
    ST_WAIT_DATA = 3'd4,
    ST_WAIT_CLR  = 3'd6
  } chan_state_e;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_INIT = 2'd2,
    SEL_EN   = 2'd3
  } sw_sel_e;

endpackage

// File: rtl/chan_sw_decode.sv
module chan_sw_decode
  import reg_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_we_i,
  input  logic [1:0] sw_sel_i,
  input  logic       sw_bit0_i,
  output logic       cmd_wr_o,
  output logic       clr_o,
  output logic       en_o,
  output logic       init_done_o
);

  logic en_q, init_q;
  logic sel_en, sel_init;

  assign sel_en   = sw_we_i && (sw_sel_i == SEL_EN);
  assign sel_init = sw_we_i && (sw_sel_i == SEL_INIT);

  assign cmd_wr_o = sw_we_i && (sw_sel_i == SEL_CMD);
  assign clr_o    = sw_we_i && (sw_sel_i == SEL_CLR) && sw_bit0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      init_q <= 1'b0;
    end else begin
      if (sel_en) en_q <= sw_bit0_i;
      if (sel_init && sw_bit0_i) init_q <= 1'b1;
    end
  end

  assign en_o        = en_q;
  assign init_done_o = init_q;

  assert_init_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> init_q);

  assert_en_only_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_en |=> $stable(en_q));

endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
  import reg_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CMD_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              clr_i,
  output logic              be_req_o,
  output logic              be_write_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [DATA_W-1:0] be_wdata_o,
  input  logic              be_done_i,
  input  logic [DATA_W-1:0] be_rdata_i,
  output chan_state_e       state_o,
  output logic              req_pend_o,
  output logic              sync_idle_o,
  output logic [DATA_W-1:0] rdata_o
);

  chan_state_e       state_q, state_d;
  logic [CMD_W-1:0]  cmd_q;
  logic              outst_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept, issue, cmd_is_wr;

  assign cmd_is_wr = cmd_q[CMD_W-1];
  assign accept    = cmd_wr_i && en_i && (state_q == ST_IDLE);
  // hold the request until the back end has answered the previous one
  assign issue     = (state_q == ST_REQ) && !outst_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept)    state_d = ST_REQ;
      ST_REQ:       if (issue)     state_d = cmd_is_wr ? ST_IDLE : ST_WAIT_DATA;
      ST_WAIT_DATA: if (be_done_i) state_d = ST_WAIT_CLR;
      ST_WAIT_CLR:  if (clr_i)     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      outst_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) cmd_q <= cmd_i;
      if (issue) outst_q <= 1'b1;
      else if (be_done_i) outst_q <= 1'b0;
      if ((state_q == ST_WAIT_DATA) && be_done_i) rdata_q <= be_rdata_i;
    end
  end

  assign be_req_o    = issue;
  assign be_write_o  = cmd_is_wr;
  assign be_addr_o   = cmd_q[CMD_W-2 -: ADDR_W];
  assign be_wdata_o  = cmd_q[DATA_W-1:0];
  assign state_o     = state_q;
  assign req_pend_o  = (state_q == ST_REQ);
  assign sync_idle_o = !outst_q;
  assign rdata_o     = rdata_q;

  assert_req_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |=> !be_req_o);

  assert_write_to_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_o && be_write_o) |=> (state_q == ST_IDLE));

  assert_read_to_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_o && !be_write_o) |=> (state_q == ST_WAIT_DATA));

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT_DATA) && be_done_i) |=>
      ((state_q == ST_WAIT_CLR) && (rdata_q == $past(be_rdata_i))));

  assert_hold_until_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT_CLR) && !clr_i) |=> ((state_q == ST_WAIT_CLR) && $stable(rdata_q)));

  assert_busy_cmd_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != ST_IDLE) && cmd_wr_i) |=> $stable(cmd_q));

  assert_disabled_stays_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && !en_i) |=> (state_q == ST_IDLE));

  assert_req_when_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |-> sync_idle_o);

endmodule

// File: rtl/chan_status_pack.sv
module chan_status_pack
  import reg_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAT_W = 32
) (
  input  chan_state_e       state_i,
  input  logic              req_pend_i,
  input  logic              sync_idle_i,
  input  logic              init_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [STAT_W-1:0] status_o
);

  localparam int unsigned ST_LSB   = DATA_W;
  localparam int unsigned PEND_BIT = DATA_W + STATE_W;
  localparam int unsigned SYNC_BIT = PEND_BIT + 1;
  localparam int unsigned INIT_BIT = PEND_BIT + 2;
  localparam int unsigned SYS_BIT  = PEND_BIT + 3;

  always_comb begin
    status_o                      = '0;
    status_o[DATA_W-1:0]          = rdata_i;
    status_o[ST_LSB +: STATE_W]   = state_i;
    status_o[PEND_BIT]            = req_pend_i;
    status_o[SYNC_BIT]            = sync_idle_i;
    status_o[INIT_BIT]            = init_done_i;
    status_o[SYS_BIT]             = sync_idle_i && (state_i == ST_IDLE);
  end

endmodule

// File: rtl/reg_access_chan.sv
module reg_access_chan
  import reg_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CMD_W  = 1 + ADDR_W + DATA_W,
  localparam int unsigned STAT_W = DATA_W + 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_sel_i,
  input  logic [CMD_W-1:0]  sw_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              be_req_o,
  output logic              be_write_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [DATA_W-1:0] be_wdata_o,
  input  logic              be_done_i,
  input  logic [DATA_W-1:0] be_rdata_i
);

  logic              cmd_wr, clr, en, init_done;
  chan_state_e       state;
  logic              req_pend, sync_idle;
  logic [DATA_W-1:0] rdata;

  chan_sw_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (sw_we_i),
    .sw_sel_i    (sw_sel_i),
    .sw_bit0_i   (sw_wdata_i[0]),
    .cmd_wr_o    (cmd_wr),
    .clr_o       (clr),
    .en_o        (en),
    .init_done_o (init_done)
  );

  chan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .cmd_wr_i    (cmd_wr),
    .cmd_i       (sw_wdata_i),
    .clr_i       (clr),
    .be_req_o    (be_req_o),
    .be_write_o  (be_write_o),
    .be_addr_o   (be_addr_o),
    .be_wdata_o  (be_wdata_o),
    .be_done_i   (be_done_i),
    .be_rdata_i  (be_rdata_i),
    .state_o     (state),
    .req_pend_o  (req_pend),
    .sync_idle_o (sync_idle),
    .rdata_o     (rdata)
  );

  chan_status_pack #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_status (
    .state_i     (state),
    .req_pend_i  (req_pend),
    .sync_idle_i (sync_idle),
    .init_done_i (init_done),
    .rdata_i     (rdata),
    .status_o    (status_o)
  );

endmodule

// File: tb/reg_access_chan_test.sv
module reg_access_chan_test;
  localparam int AW = 15;
  localparam int DW = 16;
  localparam int CW = 32;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic          sw_we = 1'b0;
  logic [1:0]    sw_sel = 2'd0;
  logic [CW-1:0] sw_wdata = '0;
  logic [SW-1:0] status;
  logic          be_req, be_write;
  logic [AW-1:0] be_addr;
  logic [DW-1:0] be_wdata;
  logic          be_done = 1'b0;
  logic [DW-1:0] be_rdata = '0;

  reg_access_chan uut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_we_i(sw_we), .sw_sel_i(sw_sel),
    .sw_wdata_i(sw_wdata), .status_o(status), .be_req_o(be_req),
    .be_write_o(be_write), .be_addr_o(be_addr), .be_wdata_o(be_wdata),
    .be_done_i(be_done), .be_rdata_i(be_rdata)
  );

  int checks = 0, fails = 0, req_seen = 0, cycles = 0, lat = 0;
  logic [DW-1:0] model_mem [32];
  logic [DW-1:0] exp_mem [32];
  bit busy = 1'b0;
  int cnt = 0;
  logic [DW-1:0] resp = '0;

  function automatic logic [DW-1:0] seed_val(input int i);
    return DW'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  // back-end model: acts on the falling edge
  always @(negedge clk) begin
    be_done = 1'b0;
    if (busy) begin
      if (cnt == 0) begin be_done = 1'b1; be_rdata = resp; busy = 1'b0; end
      else cnt--;
    end
    if (be_req) begin
      busy = 1'b1;
      cnt = lat;
      if (be_write) model_mem[be_addr[4:0]] = be_wdata;
      resp = model_mem[be_addr[4:0]];
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (be_req) req_seen++;
    if (cycles >= 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [CW-1:0] d);
    @(negedge clk); sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(input string tag);
    int k = 0;
    while (!be_req && k < 40) begin @(negedge clk); k++; end
    check(be_req, tag, 32'(be_req), 32'd1);
  endtask

  task automatic wait_state(input logic [2:0] code, input string tag);
    int k = 0;
    while (status[18:16] != code && k < 60) begin @(negedge clk); k++; end
    check(status[18:16] == code, tag, 32'(status[18:16]), 32'(code));
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int l);
    lat = l;
    sw_write(2'd0, {1'b1, a, d});
    wait_req("R2 write request raised");
    check(be_write && be_addr == a && be_wdata == d, "R2 write fields",
          {be_write, be_addr, be_wdata}, {1'b1, a, d});
    exp_mem[a[4:0]] = d;
    @(negedge clk);
    check(status[18:16] == 3'd0, "R3 write returns to IDLE", 32'(status[18:16]), 32'd0);
    check(!be_req, "R3 single-cycle request", 32'(be_req), 32'd0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int l, input bit stray);
    logic [DW-1:0] held;
    int r0;
    lat = l;
    sw_write(2'd0, {1'b0, a, 16'h0000});
    wait_req("R2 read request raised");
    check(!be_write && be_addr == a, "R2 read fields", {be_write, be_addr}, {1'b0, a});
    @(negedge clk);
    check(status[18:16] == 3'd4, "R4 WAIT_DATA after request", 32'(status[18:16]), 32'd4);
    wait_state(3'd6, "R4 reaches WAIT_CLEAR");
    check(status[15:0] == exp_mem[a[4:0]], "R4 read data", 32'(status[15:0]), 32'(exp_mem[a[4:0]]));
    held = status[15:0];
    if (stray) begin
      r0 = req_seen;
      sw_write(2'd0, {1'b1, ~a, 16'hDEAD});
      idle(3);
      check(status[18:16] == 3'd6 && status[15:0] == held, "R6 command ignored when busy",
            status, {13'h0, 3'd6, held});
      check(req_seen == r0, "R6 no request from dropped command", req_seen, r0);
    end
    idle(2);
    check(status[18:16] == 3'd6, "R5 holds without clear", 32'(status[18:16]), 32'd6);
    sw_write(2'd1, 32'h0);
    check(status[18:16] == 3'd6 && status[15:0] == held, "R5 clear with bit0=0 ignored",
          status, {13'h0, 3'd6, held});
    sw_write(2'd1, 32'h1);
    check(status[18:16] == 3'd0, "R5 clear returns to IDLE", 32'(status[18:16]), 32'd0);
  endtask

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int r0;
    void'($urandom(32'd7331));
    for (int i = 0; i < 32; i++) begin
      model_mem[i] = seed_val(i);
      exp_mem[i]   = seed_val(i);
    end
    idle(3);
    check(status == 32'h0050_0000, "R1 status in reset", status, 32'h0050_0000);
    check(!be_req, "R1 no request in reset", 32'(be_req), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(status == 32'h0050_0000, "R1 status after reset", status, 32'h0050_0000);

    // R7: disabled channel drops commands
    r0 = req_seen;
    sw_write(2'd0, {1'b1, 15'h0003, 16'h1111});
    idle(3);
    check(status[18:16] == 3'd0, "R7 disabled stays IDLE", 32'(status[18:16]), 32'd0);
    check(req_seen == r0, "R7 disabled raises no request", req_seen, r0);

    // R8: init-done is sticky
    check(status[21] == 1'b0, "R8 init-done clear", 32'(status[21]), 32'd0);
    sw_write(2'd2, 32'h0);
    check(status[21] == 1'b0, "R8 zero write no effect", 32'(status[21]), 32'd0);
    sw_write(2'd2, 32'h1);
    check(status[21] == 1'b1, "R8 init-done set", 32'(status[21]), 32'd1);
    sw_write(2'd2, 32'h0);
    check(status[21] == 1'b1, "R8 init-done not cleared", 32'(status[21]), 32'd1);

    sw_write(2'd3, 32'h1);

    // R9: sync-idle and system-idle follow the back end
    do_write(15'h0005, 16'hBEEF, 5);
    check(status[20] == 1'b0 && status[22] == 1'b0, "R9 busy while outstanding",
          32'(status[22:20]), 32'd0);
    idle(10);
    check(status[20] == 1'b1 && status[22] == 1'b1, "R9 idle after done",
          32'(status[22:20]), 32'h5 | 32'(status[21] << 1));

    // R10: queued command waits for the earlier write
    do_write(15'h000A, 16'h1234, 6);
    sw_write(2'd0, {1'b1, 15'h000B, 16'h5678});
    check(status[18:16] == 3'd2 && status[19] == 1'b1, "R10 waits in REQ with pending",
          32'(status[19:16]), 32'hA);
    check(!be_req, "R10 no request while outstanding", 32'(be_req), 32'd0);
    wait_req("R10 request after done");
    check(status[20] == 1'b1 && be_addr == 15'h000B, "R10 issued when back end free",
          {status[20], be_addr}, {1'b1, 15'h000B});
    exp_mem[5'h0B] = 16'h5678;
    idle(10);

    do_read(15'h0005, 0, 1'b0);
    do_read(15'h000B, 3, 1'b1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      a = 15'($urandom);
      d = 16'($urandom);
      if ($urandom % 2 == 0) do_write(a, d, int'($urandom % 4));
      else do_read(a, int'($urandom % 4), ($urandom % 4) == 0);
    end

    // R1: reset mid-access clears held data and flags
    lat = 0;
    sw_write(2'd0, {1'b0, 15'h0009, 16'h0000});
    wait_state(3'd6, "R4 read before reset");
    idle(2);
    rst_ni = 1'b0;
    @(negedge clk);
    check(status == 32'h0050_0000, "R1 reset clears state", status, 32'h0050_0000);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!be_req && status == 32'h0050_0000, "R1 idle after reset release",
          status, 32'h0050_0000);

    summary();
    $finish;
  end
endmodule